// File: doc/BRIEF.md
# Control-Word Steered Register Datapath

This block is the execution core of a small processor. It holds seven general registers, R1 to R7. Each clock cycle a 14-bit control word steers it. Two fields of the word pick the two ALU operands. Each operand comes from a register or from an external data input. A third field picks which register, if any, captures the ALU result at the next rising clock edge. The last field picks the ALU operation. The ALU result always appears on an external data output in the same cycle.

A status register of four flags (carry, sign, zero, overflow) loads from every ALU result at the clock edge. Carry and overflow come from the adder on arithmetic operations. On all other operations they are cleared. A sequencer outside the block supplies one control word per cycle, for example from a control memory. Sequencing and decoding are not part of this block.

Top module: `cw_regpath`

## Requirements
- R1: The control word is split, from the most significant bit down, into source A select [13:11], source B select [10:8], destination select [7:5] and operation code [4:0].
- R2: A source select of 000 places the external input on that ALU operand. A code k from 1 to 7 places register Rk on it.
- R3: A destination code k from 1 to 7 loads the ALU result into Rk at the rising clock edge and leaves every other register unchanged. Code 000 loads no register.
- R4: The external output equals the ALU result combinationally in the same cycle, whatever the destination code is, 000 included.
- R5: Arithmetic operations wrap modulo 256: 00001 gives A+1, 00010 gives A+B, 00101 gives A-B (computed as A plus the two's complement of B), and 00110 gives A-1.
- R6: Logic operations: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, and 01110 gives the bitwise complement of A.
- R7: 10000 shifts A right by one with a 0 filled in at the top. 11000 shifts A left by one with a 0 filled in at the bottom. 00000 passes A and 11100 passes B. Every other code passes A.
- R8: After an arithmetic operation, the carry flag holds the carry out of bit 7. For A=F0h minus B=14h, the result is DCh and the flags are C=1, S=1, Z=0, V=0.
- R9: After an arithmetic operation, the overflow flag holds the XOR of the carry into bit 7 and the carry out of bit 7.
- R10: After every operation, sign equals result bit 7 and zero is 1 exactly when the result is 00h. After any non-arithmetic operation, carry and overflow are 0. The flags load at the clock edge that ends the operation's cycle.
- R11: While the active-low reset is asserted, all registers and all flags are 0, and no clock edge changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers and flags load on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 14 | Control word: source A, source B, destination, operation |
| ext_in | input | 8 | External data, selected by source code 000 |
| ext_out | output | 8 | ALU result, combinational |
| flag_c | output | 1 | Carry flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench builds the block with its default parameters: 8-bit data and 3-bit select fields, which give seven registers and a 14-bit control word. At that width the bench can use the given subtraction case (F0h minus 14h), the signed boundaries at 7Fh and 80h, and the carry wrap at FFh. Every select code from 000 to 111 appears on both source fields and on the destination field. Registers are read back through the external output by passing them unchanged to the ALU.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_PASS_A = 5'b00000,
      OP_INC_A  = 5'b00001,
      OP_ADD    = 5'b00010,
      OP_SUB    = 5'b00101,
      OP_DEC_A  = 5'b00110,
      OP_AND    = 5'b01000,
      OP_OR     = 5'b01010,
      OP_XOR    = 5'b01100,
      OP_NOT_A  = 5'b01110,
      OP_SHR_A  = 5'b10000,
      OP_SHL_A  = 5'b11000,
      OP_PASS_B = 5'b11100
   } alu_op_e;

   function automatic logic op_is_arith(input logic [OP_W-1:0] op);
      return (op == OP_INC_A) || (op == OP_ADD) ||
             (op == OP_SUB)   || (op == OP_DEC_A);
   endfunction

endpackage

// File: rtl/cwp_srcmux.sv
module cwp_srcmux #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   localparam int NUM_REGS = (1 << SEL_W) - 1
) (
   input  logic [SEL_W-1:0]                 sel_i,
   input  logic [DATA_W-1:0]                ext_i,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_i,
   output logic [DATA_W-1:0]                opnd_o
);

   // code 0 selects the external input, code k selects register k
   always_comb begin
      opnd_o = ext_i;
      for (int k = 1; k <= NUM_REGS; k++) begin
         if (sel_i == SEL_W'(k)) opnd_o = regs_i[k-1];
      end
   end

endmodule

// File: rtl/cwp_regfile.sv
module cwp_regfile #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   localparam int NUM_REGS = (1 << SEL_W) - 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [SEL_W-1:0]                 dest_i,
   input  logic [DATA_W-1:0]                wdata_i,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

   logic [NUM_REGS-1:0] load_en;

   // destination decoder: one enable per register, code 0 enables none
   always_comb begin
      for (int k = 1; k <= NUM_REGS; k++) begin
         load_en[k-1] = (dest_i == SEL_W'(k));
      end
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          regs_o[g] <= '0;
         else if (load_en[g]) regs_o[g] <= wdata_i;
      end

      assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !load_en[g] |=> $stable(regs_o[g]));

      assert_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
         load_en[g] |=> regs_o[g] == $past(wdata_i));
   end

   assert_no_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dest_i == '0 |=> $stable(regs_o));

endmodule

// File: rtl/cwp_alu.sv
module cwp_alu
   import cwp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o,
   output logic              arith_o,
   output logic              cout_o,
   output logic              ovf_o
);

   logic [DATA_W-1:0] add_y;
   logic              add_cin;
   logic [DATA_W:0]   add_sum;
   logic              carry_top_in;

   // one adder shared by every arithmetic operation
   always_comb begin
      add_y   = '0;
      add_cin = 1'b0;
      case (op_i)
         OP_INC_A: add_cin = 1'b1;
         OP_ADD:   add_y   = b_i;
         OP_SUB: begin
            add_y   = ~b_i;
            add_cin = 1'b1;
         end
         OP_DEC_A: add_y = '1;
         default:  add_y = '0;
      endcase
   end

   assign add_sum      = {1'b0, a_i} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_cin};
   assign carry_top_in = add_sum[DATA_W-1] ^ a_i[DATA_W-1] ^ add_y[DATA_W-1];
   assign cout_o       = add_sum[DATA_W];
   assign ovf_o        = add_sum[DATA_W] ^ carry_top_in;
   assign arith_o      = op_is_arith(op_i);

   always_comb begin
      case (op_i)
         OP_INC_A, OP_ADD, OP_SUB, OP_DEC_A: res_o = add_sum[DATA_W-1:0];
         OP_AND:    res_o = a_i & b_i;
         OP_OR:     res_o = a_i | b_i;
         OP_XOR:    res_o = a_i ^ b_i;
         OP_NOT_A:  res_o = ~a_i;
         OP_SHR_A:  res_o = {1'b0, a_i[DATA_W-1:1]};
         OP_SHL_A:  res_o = {a_i[DATA_W-2:0], 1'b0};
         OP_PASS_B: res_o = b_i;
         default:   res_o = a_i;
      endcase
   end

endmodule

// File: rtl/cwp_flags.sv
module cwp_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] res_i,
   input  logic              arith_i,
   input  logic              cout_i,
   input  logic              ovf_i,
   output logic              c_o,
   output logic              s_o,
   output logic              z_o,
   output logic              v_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_o <= 1'b0;
         s_o <= 1'b0;
         z_o <= 1'b0;
         v_o <= 1'b0;
      end else begin
         c_o <= arith_i & cout_i;
         v_o <= arith_i & ovf_i;
         s_o <= res_i[DATA_W-1];
         z_o <= (res_i == '0);
      end
   end

   assert_clear_cv_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !arith_i |=> !c_o && !v_o);

   assert_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_i == '0 |=> z_o);

   assert_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_i != '0 |=> !z_o);

endmodule

// File: rtl/cw_regpath.sv
module cw_regpath
   import cwp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   localparam int CW_W  = 3 * SEL_W + OP_W,
   localparam int NUM_REGS = (1 << SEL_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW_W-1:0]   ctrl_word,
   input  logic [DATA_W-1:0] ext_in,
   output logic [DATA_W-1:0] ext_out,
   output logic              flag_c,
   output logic              flag_s,
   output logic              flag_z,
   output logic              flag_v
);

   if (DATA_W < 2) begin : g_bad_width
      $error("cw_regpath: DATA_W must be at least 2");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("cw_regpath: SEL_W must be between 1 and 4");
   end

   logic [SEL_W-1:0] sel_a, sel_b, sel_d;
   logic [OP_W-1:0]  op;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic [DATA_W-1:0] opnd [2];
   logic [SEL_W-1:0]  src_sel [2];
   logic [DATA_W-1:0] alu_res;
   logic              alu_arith, alu_cout, alu_ovf;

   assign sel_a = ctrl_word[CW_W-1 -: SEL_W];
   assign sel_b = ctrl_word[CW_W-SEL_W-1 -: SEL_W];
   assign sel_d = ctrl_word[OP_W+SEL_W-1 -: SEL_W];
   assign op    = ctrl_word[OP_W-1:0];

   assign src_sel[0] = sel_a;
   assign src_sel[1] = sel_b;

   for (genvar p = 0; p < 2; p++) begin : g_src
      cwp_srcmux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mux (
         .sel_i  (src_sel[p]),
         .ext_i  (ext_in),
         .regs_i (regs),
         .opnd_o (opnd[p])
      );
   end

   cwp_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .dest_i  (sel_d),
      .wdata_i (alu_res),
      .regs_o  (regs)
   );

   cwp_alu #(.DATA_W(DATA_W)) u_alu (
      .op_i    (op),
      .a_i     (opnd[0]),
      .b_i     (opnd[1]),
      .res_o   (alu_res),
      .arith_o (alu_arith),
      .cout_o  (alu_cout),
      .ovf_o   (alu_ovf)
   );

   cwp_flags #(.DATA_W(DATA_W)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .res_i   (alu_res),
      .arith_i (alu_arith),
      .cout_i  (alu_cout),
      .ovf_i   (alu_ovf),
      .c_o     (flag_c),
      .s_o     (flag_s),
      .z_o     (flag_z),
      .v_o     (flag_v)
   );

   assign ext_out = alu_res;

   assert_add_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_ADD |-> {alu_cout, alu_res} == ({1'b0, opnd[0]} + {1'b0, opnd[1]}));

   assert_add_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ADD && opnd[0][DATA_W-1] == opnd[1][DATA_W-1])
         |-> alu_ovf == (alu_res[DATA_W-1] != opnd[0][DATA_W-1]));

   assert_add_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ADD && opnd[0][DATA_W-1] != opnd[1][DATA_W-1]) |-> !alu_ovf);

   assert_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> flag_s == $past(ext_out[DATA_W-1]));

endmodule

// File: tb/tb_cw_regpath.sv
module tb_cw_regpath;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [13:0] ctrl_word;
   logic [7:0]  ext_in;
   logic [7:0]  ext_out;
   logic        flag_c, flag_s, flag_z, flag_v;

   int checks = 0;
   int errors = 0;

   // operation codes as listed in the requirements (R5, R6, R7)
   localparam logic [4:0] PA  = 5'b00000, INC = 5'b00001, ADD = 5'b00010,
                          SUB = 5'b00101, DEC = 5'b00110, AND = 5'b01000,
                          ORR = 5'b01010, XOR = 5'b01100, COM = 5'b01110,
                          SHR = 5'b10000, SHL = 5'b11000, PB  = 5'b11100;

   cw_regpath dut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ext_in(ext_in),
      .ext_out(ext_out), .flag_c(flag_c), .flag_s(flag_s),
      .flag_z(flag_z), .flag_v(flag_v)
   );

   always #10 clk = ~clk;

   // field order per R1: A, B, destination, operation
   function automatic logic [13:0] mk(input logic [2:0] a, input logic [2:0] b,
                                      input logic [2:0] d, input logic [4:0] op);
      return {a, b, d, op};
   endfunction

   task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // flags compared as {C,S,Z,V}
   task automatic chkf(input logic [3:0] exp, input string tag);
      checks++;
      if ({flag_c, flag_s, flag_z, flag_v} !== exp) begin
         errors++;
         $display("FAIL %s flags CSZV: actual %b expected %b", tag,
                  {flag_c, flag_s, flag_z, flag_v}, exp);
      end
   endtask

   // drive one control word, check the output in-cycle, then flags after the edge
   task automatic step(input logic [13:0] cw, input logic [7:0] din,
                       input logic [7:0] exp_out, input logic [3:0] exp_f,
                       input string tag);
      ctrl_word = cw;
      ext_in    = din;
      #3;
      chk8(ext_out, exp_out, tag);
      @(posedge clk); #2;
      chkf(exp_f, tag);
   endtask

   // load register k from the external input
   task automatic load(input int k, input logic [7:0] v);
      ctrl_word = mk(3'd0, 3'd0, 3'(k), PA);
      ext_in    = v;
      #3;
      chk8(ext_out, v, "R4 external load visible");
      @(posedge clk); #2;
   endtask

   // read register k through source A with no destination
   task automatic readreg(input int k, input logic [7:0] exp, input string tag);
      ctrl_word = mk(3'(k), 3'd0, 3'd0, PA);
      ext_in    = 8'h00;
      #3;
      chk8(ext_out, exp, tag);
      @(posedge clk); #2;
   endtask

   task automatic t_reset;
      rst_n     = 1'b0;
      ctrl_word = mk(3'd0, 3'd0, 3'd1, SUB);
      ext_in    = 8'h5A;
      repeat (3) @(posedge clk);
      #2;
      chkf(4'b0000, "R11 flags held in reset");
      rst_n = 1'b1;
      @(posedge clk); #2;
      for (int k = 1; k <= 7; k++) readreg(k, 8'h00, "R11 register zero after reset");
   endtask

   task automatic t_load_and_select;
      for (int k = 1; k <= 7; k++) load(k, 8'(k * 8'h11));
      for (int k = 1; k <= 7; k++) readreg(k, 8'(k * 8'h11), "R2 source A register select");
      for (int k = 1; k <= 7; k++) begin
         ctrl_word = mk(3'd0, 3'(k), 3'd0, PB);
         ext_in = 8'hC3;
         #3;
         chk8(ext_out, 8'(k * 8'h11), "R2 source B register select");
         @(posedge clk); #2;
      end
      step(mk(3'd0, 3'd0, 3'd0, PB), 8'hC3, 8'hC3, 4'b0100, "R2 source B external");
   endtask

   task automatic t_dest;
      step(mk(3'd1, 3'd2, 3'd0, ADD), 8'h00, 8'h33, 4'b0000, "R4 result with no destination");
      for (int k = 1; k <= 7; k++) readreg(k, 8'(k * 8'h11), "R3 no register loaded by code 000");
      step(mk(3'd2, 3'd5, 3'd4, XOR), 8'h00, 8'h77, 4'b0000, "R1 field split xor");
      readreg(4, 8'h77, "R3 destination loaded");
      readreg(3, 8'h33, "R3 neighbour below unchanged");
      readreg(5, 8'h55, "R3 neighbour above unchanged");
   endtask

   task automatic t_arith;
      load(1, 8'hF0);
      load(2, 8'h14);
      step(mk(3'd1, 3'd2, 3'd3, SUB), 8'h00, 8'hDC, 4'b1100, "R8 subtraction example");
      readreg(3, 8'hDC, "R5 subtraction written back");
      load(6, 8'h01);
      step(mk(3'd0, 3'd6, 3'd0, ADD), 8'h7F, 8'h80, 4'b0101, "R9 add positive overflow");
      step(mk(3'd0, 3'd6, 3'd0, SUB), 8'h80, 8'h7F, 4'b1001, "R9 sub negative overflow");
      step(mk(3'd0, 3'd6, 3'd0, SUB), 8'h01, 8'h00, 4'b1010, "R8 sub equal operands");
      step(mk(3'd0, 3'd0, 3'd0, INC), 8'hFF, 8'h00, 4'b1010, "R5 increment wrap");
      step(mk(3'd0, 3'd0, 3'd0, INC), 8'h7F, 8'h80, 4'b0101, "R9 increment overflow");
      step(mk(3'd0, 3'd0, 3'd0, DEC), 8'h00, 8'hFF, 4'b0100, "R5 decrement zero");
      step(mk(3'd0, 3'd0, 3'd0, DEC), 8'h80, 8'h7F, 4'b1001, "R9 decrement overflow");
      step(mk(3'd0, 3'd1, 3'd5, ADD), 8'h01, 8'hF1, 4'b0100, "R5 add external and register");
   endtask

   task automatic t_logic;
      step(mk(3'd0, 3'd6, 3'd0, ADD), 8'hFF, 8'h00, 4'b1010, "R8 add carry out");
      step(mk(3'd0, 3'd1, 3'd0, AND), 8'h0F, 8'h00, 4'b0010, "R10 and clears carry, zero set");
      step(mk(3'd1, 3'd2, 3'd0, AND), 8'h00, 8'h10, 4'b0000, "R6 and");
      step(mk(3'd1, 3'd2, 3'd0, ORR), 8'h00, 8'hF4, 4'b0100, "R6 or");
      step(mk(3'd1, 3'd2, 3'd0, XOR), 8'h00, 8'hE4, 4'b0100, "R6 xor");
      step(mk(3'd1, 3'd0, 3'd0, COM), 8'h00, 8'h0F, 4'b0000, "R6 complement");
   endtask

   task automatic t_shift;
      step(mk(3'd0, 3'd6, 3'd0, SUB), 8'h80, 8'h7F, 4'b1001, "R9 set overflow before shift");
      step(mk(3'd1, 3'd0, 3'd0, SHL), 8'h00, 8'hE0, 4'b0100, "R10 shift left clears carry");
      step(mk(3'd1, 3'd0, 3'd0, SHR), 8'h00, 8'h78, 4'b0000, "R7 shift right");
      step(mk(3'd0, 3'd2, 3'd0, PB), 8'hAA, 8'h14, 4'b0000, "R7 pass B");
      step(mk(3'd1, 3'd2, 3'd0, 5'b00011), 8'h00, 8'hF0, 4'b0100, "R7 unused code passes A");
      step(mk(3'd1, 3'd2, 3'd0, 5'b11111), 8'h00, 8'hF0, 4'b0100, "R7 unused code 11111");
      step(mk(3'd0, 3'd2, 3'd0, PA), 8'h00, 8'h00, 4'b0010, "R7 pass A external zero");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset;
      t_load_and_select;
      t_dest;
      t_arith;
      t_logic;
      t_shift;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule